// File: doc/BRIEF.md
# Edge-Count Frequency Comparator

This block decides which of two square waves runs faster. One is an unknown input; the other is the hard-limited output of a synthesizer inside a frequency-tracking loop. Both arrive asynchronously. Each one is brought into the system clock domain, and its 0-to-1 transitions are turned into single-cycle edge strobes.

Two saturating edge counters then judge the pair. The first counts unknown edges that fall inside one synthesizer period. The second counts synthesizer edges that fall inside one unknown period. When a counter reaches its trigger count of two, it fires a verdict event. A two-state machine holds the verdict.

The verdict machine has two states:
- LOWER (`raise_cmd` = 0): the synthesizer frequency should come down.
- RAISE (`raise_cmd` = 1): the synthesizer frequency should go up.

It has three transitions:
- LOWER to RAISE on a lone raise event.
- RAISE to LOWER on a lone lower event.
- Hold in every other cycle, including a cycle in which both counters fire together.

The verdict can be wrong for some periods after the frequency relation changes. How long depends on how the edges line up at the start, so the loop must tolerate that lag.

Top module: `edge_count_freq_cmp`

## Requirements
- R1: While `rst_n` is low and after its release, `raise_cmd`, `raise_evt` and `lower_evt` are 0 and both edge counters are 0.
- R2: Each input passes through a two-flop synchronizer, and only a 0-to-1 transition of the synchronized value counts as an edge. A level held high counts once. An input rising just after clock edge n takes effect at clock edge n+3.
- R3: The unknown-edge counter adds one per unknown edge and saturates at two. Further unknown edges in the same synthesizer period produce no event.
- R4: The synthesizer-edge counter adds one per synthesizer edge and saturates at two. Further synthesizer edges in the same unknown period produce no event.
- R5: A synthesizer edge clears the unknown-edge counter, and an unknown edge clears the synthesizer-edge counter. An edge that coincides with the clearing edge is counted in the period that closes, and also as the first edge of the new period.
- R6: When only the unknown-edge counter reaches two in a cycle, `raise_evt` pulses and the machine enters RAISE (`raise_cmd` = 1).
- R7: When only the synthesizer-edge counter reaches two in a cycle, `lower_evt` pulses and the machine enters LOWER (`raise_cmd` = 0).
- R8: When both counters reach two in the same cycle, neither event fires and `raise_cmd` keeps its value.
- R9: Each event lasts exactly one cycle, the two events never coincide, and `raise_cmd` changes only in a cycle with an event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| unk_in | input | 1 | Unknown square wave, asynchronous |
| syn_in | input | 1 | Hard-limited synthesizer square wave, asynchronous |
| raise_cmd | output | 1 | Verdict: 1 means count the synthesizer up, 0 means count it down |
| raise_evt | output | 1 | Single-cycle pulse when the unknown-edge counter alone reaches two |
| lower_evt | output | 1 | Single-cycle pulse when the synthesizer-edge counter alone reaches two |

## Verification
An input edge takes three register stages to reach the outputs: two synchronizer flops, then the registered events and state. An event caused by an edge driven just after clock edge n is therefore due at edge n+3, and `raise_cmd` moves on that same edge.

The driver changes the inputs only on falling clock edges. When it drives an edge that should fire an event, it queues the event's kind together with the cycle number plus three. The monitor samples on falling edges, matches every pulse against the head of the queue by kind and cycle, and reports any queued event whose cycle passes without a pulse. The verdict level is read on the falling edge after the three-cycle latency has elapsed.

// File: rtl/efc_pkg.sv
package efc_pkg;

    // Channel indices into the per-input arrays
    localparam int CH_UNK = 0;
    localparam int CH_SYN = 1;
    localparam int NUM_CH = 2;

    // Verdict held by the decision machine
    typedef enum logic [0:0] {
        VERDICT_LOWER = 1'b0,
        VERDICT_RAISE = 1'b1
    } verdict_e;

endpackage

// File: rtl/efc_sync_edge.sv
module efc_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);

    logic [STAGES-1:0] chain_q;
    logic              last_q;

    // Synchronizer chain, then one history flop for edge detection
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
            last_q  <= 1'b0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_in};
            last_q  <= chain_q[STAGES-1];
        end
    end

    assign rise = chain_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/efc_sat_counter.sv
module efc_sat_counter #(
    parameter int LIMIT = 2,
    parameter int CW    = $clog2(LIMIT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    input  logic          clr,
    output logic [CW-1:0] cnt,
    output logic          hit
);

    localparam logic [CW-1:0] TOP_V = CW'(LIMIT);
    localparam logic [CW-1:0] PRE_V = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_d;

    // A coincident edge closes the old window (hit) and opens the new one at 1
    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = inc ? CW'(1) : '0;
        end else if (inc && (cnt_q != TOP_V)) begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign hit = inc && (cnt_q == PRE_V);
    assign cnt = cnt_q;

endmodule

// File: rtl/efc_verdict_fsm.sv
module efc_verdict_fsm
    import efc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit_up,
    input  logic hit_down,
    output logic raise_cmd,
    output logic raise_evt,
    output logic lower_evt
);

    verdict_e state_q;
    verdict_e state_d;
    logic     raise_evt_q;
    logic     lower_evt_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            VERDICT_LOWER: if (hit_up && !hit_down) state_d = VERDICT_RAISE;
            VERDICT_RAISE: if (hit_down && !hit_up) state_d = VERDICT_LOWER;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= VERDICT_LOWER;
        end else begin
            state_q <= state_d;
        end
    end

    // Event outputs, registered so that they line up with the state change
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raise_evt_q <= 1'b0;
            lower_evt_q <= 1'b0;
        end else begin
            raise_evt_q <= hit_up && !hit_down;
            lower_evt_q <= hit_down && !hit_up;
        end
    end

    assign raise_cmd = (state_q == VERDICT_RAISE);
    assign raise_evt = raise_evt_q;
    assign lower_evt = lower_evt_q;

endmodule

// File: rtl/edge_count_freq_cmp.sv
module edge_count_freq_cmp
    import efc_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int TRIG_COUNT  = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic unk_in,
    input  logic syn_in,
    output logic raise_cmd,
    output logic raise_evt,
    output logic lower_evt
);

    localparam int CNT_W = $clog2(TRIG_COUNT + 1);

    logic [NUM_CH-1:0] raw_in;
    logic [NUM_CH-1:0] rise;
    logic [NUM_CH-1:0] hit;
    logic [CNT_W-1:0]  cnt [NUM_CH];
    logic [CNT_W-1:0]  cnt_unk;
    logic [CNT_W-1:0]  cnt_syn;

    assign raw_in[CH_UNK] = unk_in;
    assign raw_in[CH_SYN] = syn_in;

    // Each channel counts its own edges and is cleared by the other channel
    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        efc_sync_edge #(
            .STAGES (SYNC_STAGES)
        ) u_sync (
            .clk      (clk),
            .rst_n    (rst_n),
            .async_in (raw_in[g]),
            .rise     (rise[g])
        );

        efc_sat_counter #(
            .LIMIT (TRIG_COUNT),
            .CW    (CNT_W)
        ) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (rise[g]),
            .clr   (rise[NUM_CH-1-g]),
            .cnt   (cnt[g]),
            .hit   (hit[g])
        );
    end

    assign cnt_unk = cnt[CH_UNK];
    assign cnt_syn = cnt[CH_SYN];

    efc_verdict_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .hit_up    (hit[CH_UNK]),
        .hit_down  (hit[CH_SYN]),
        .raise_cmd (raise_cmd),
        .raise_evt (raise_evt),
        .lower_evt (lower_evt)
    );

endmodule

// File: rtl/efc_checker.sv
module efc_checker #(
    parameter int TRIG = 2,
    parameter int CW   = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          raise_cmd,
    input logic          raise_evt,
    input logic          lower_evt,
    input logic [CW-1:0] cnt_a,
    input logic [CW-1:0] cnt_b
);

    p_evt_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(raise_evt && lower_evt));

    p_raise_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        raise_evt |=> !raise_evt);

    p_lower_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lower_evt |=> !lower_evt);

    p_flag_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!raise_evt && !lower_evt) |-> $stable(raise_cmd));

    p_raise_sets_r6: assert property (@(posedge clk) disable iff (!rst_n)
        raise_evt |-> raise_cmd);

    p_lower_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lower_evt |-> !raise_cmd);

    p_unk_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_a) <= TRIG);

    p_syn_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_b) <= TRIG);

    p_unk_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_a) <= int'($past(cnt_a)) + 1);

    p_syn_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(cnt_b) <= int'($past(cnt_b)) + 1);

endmodule

bind edge_count_freq_cmp efc_checker #(
    .TRIG (TRIG_COUNT),
    .CW   (CNT_W)
) u_efc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .raise_cmd (raise_cmd),
    .raise_evt (raise_evt),
    .lower_evt (lower_evt),
    .cnt_a     (cnt_unk),
    .cnt_b     (cnt_syn)
);

// File: tb/edge_count_freq_cmp_test.sv
`timescale 1ns/1ps
module edge_count_freq_cmp_test;

    localparam int EV_NONE  = 0;
    localparam int EV_RAISE = 1;
    localparam int EV_LOWER = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic unk_in = 1'b0;
    logic syn_in = 1'b0;
    logic raise_cmd;
    logic raise_evt;
    logic lower_evt;

    int cyc = 0;
    int checks = 0;
    int errors = 0;
    bit reported = 1'b0;
    bit prev_raise = 1'b0;
    bit prev_lower = 1'b0;

    typedef struct {
        int    kind;
        int    due;
        string tag;
    } exp_t;

    exp_t sb_q[$];

    edge_count_freq_cmp uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .unk_in    (unk_in),
        .syn_in    (syn_in),
        .raise_cmd (raise_cmd),
        .raise_evt (raise_evt),
        .lower_evt (lower_evt)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
        end
    endtask

    task automatic check_bit(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", tag, act, exp, cyc);
        end
    endtask

    // Drive one edge pattern for one cycle, then four cycles in total;
    // an expected event is queued for three clock edges later
    task automatic edges(input logic u, input logic s, input int ev, input string tag);
        exp_t e;
        @(negedge clk);
        unk_in = u;
        syn_in = s;
        if (ev != EV_NONE) begin
            e.kind = ev;
            e.due  = cyc + 3;
            e.tag  = tag;
            sb_q.push_back(e);
        end
        @(negedge clk);
        unk_in = 1'b0;
        syn_in = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    // Monitor: compare every event pulse with the scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (raise_evt || lower_evt) begin
                checks++;
                if ((raise_evt && lower_evt) || (raise_evt && prev_raise) || (lower_evt && prev_lower)) begin
                    errors++;
                    $display("FAIL R9: actual raise=%0b lower=%0b prev=%0b/%0b expected one single-cycle event",
                             raise_evt, lower_evt, prev_raise, prev_lower);
                end
                checks++;
                if (sb_q.size() == 0) begin
                    errors++;
                    $display("FAIL R8: actual unexpected event raise=%0b lower=%0b at cycle %0d expected none",
                             raise_evt, lower_evt, cyc);
                end else begin
                    exp_t e;
                    int act_kind;
                    e = sb_q.pop_front();
                    act_kind = raise_evt ? EV_RAISE : EV_LOWER;
                    if (act_kind != e.kind || e.due != cyc) begin
                        errors++;
                        $display("FAIL %s: actual kind=%0d cycle=%0d expected kind=%0d cycle=%0d",
                                 e.tag, act_kind, cyc, e.kind, e.due);
                    end
                end
            end else if (sb_q.size() != 0 && sb_q[0].due <= cyc) begin
                exp_t e;
                e = sb_q.pop_front();
                checks++;
                errors++;
                $display("FAIL %s: actual no event at cycle %0d expected kind=%0d", e.tag, cyc, e.kind);
            end
        end
        prev_raise = raise_evt;
        prev_lower = lower_evt;
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual run still going expected finished");
        report();
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check_bit(raise_cmd, 1'b0, "R1 flag in reset");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check_bit(raise_cmd, 1'b0, "R1 flag after reset");
        check_bit(raise_evt | lower_evt, 1'b0, "R1 events after reset");

        // R2: a long high level counts as one edge only
        @(negedge clk);
        unk_in = 1'b1;
        repeat (10) @(negedge clk);
        unk_in = 1'b0;
        repeat (3) @(negedge clk);
        check_bit(raise_cmd, 1'b0, "R2 held level counted once");

        // R6: second unknown edge in the window raises
        edges(1'b1, 1'b0, EV_RAISE, "R6");
        check_bit(raise_cmd, 1'b1, "R6 flag raised");
        // R3: saturated counter stays silent
        edges(1'b1, 1'b0, EV_NONE, "R3");
        check_bit(raise_cmd, 1'b1, "R3 saturation no event");

        // R7: two synthesizer edges inside one unknown period lower
        edges(1'b0, 1'b1, EV_NONE, "R4");
        edges(1'b0, 1'b1, EV_LOWER, "R7");
        check_bit(raise_cmd, 1'b0, "R7 flag lowered");
        edges(1'b0, 1'b1, EV_NONE, "R4");
        check_bit(raise_cmd, 1'b0, "R4 saturation no event");

        // R8: coincident edges, second pair makes both counters hit
        edges(1'b1, 1'b1, EV_NONE, "R5");
        edges(1'b1, 1'b1, EV_NONE, "R8");
        check_bit(raise_cmd, 1'b0, "R8 hold in lower");

        // R5: coincident edge starts the new window at one
        edges(1'b1, 1'b0, EV_RAISE, "R5");
        check_bit(raise_cmd, 1'b1, "R5 coincident edge counted");
        edges(1'b1, 1'b1, EV_NONE, "R5");
        edges(1'b1, 1'b1, EV_NONE, "R8");
        check_bit(raise_cmd, 1'b1, "R8 hold in raise");

        edges(1'b0, 1'b1, EV_LOWER, "R7");
        check_bit(raise_cmd, 1'b0, "R7 lowered after coincident start");

        // R5: alternating edges keep clearing, no verdict
        for (int i = 0; i < 4; i++) begin
            edges(1'b1, 1'b0, EV_NONE, "R5");
            edges(1'b0, 1'b1, EV_NONE, "R5");
        end
        check_bit(raise_cmd, 1'b0, "R5 alternating edges clear counters");

        repeat (6) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL R2: actual %0d events still pending expected 0", sb_q.size());
        end
        report();
        $finish;
    end

endmodule